// File: doc/BRIEF.md
# Reconfigurable Three-Product Multiprecision Multiplier

This block multiplies packed operands at one of three precisions on a shared array of nine small multiplier elements. A 3-bit mode word picks the lane set for each transfer: one, four or nine independent 8x8 products; one, two or three 16x16 products; or a single 32x32 product. A sign control makes the operands two's complement or unsigned. The products come out of one output register, one cycle after the transfer is presented.

Each wider product is built from three narrower products rather than four: the high halves multiplied together, the low halves multiplied together, and the product of the two half-sums. The cross term is the half-sum product minus the other two. A 16x16 lane takes three elements. The 32x32 product takes all three 16x16 groups, the third one multiplying the 16-bit parts of the 17-bit half-sums. The carry bits of those half-sums are added back as correction terms.

Signed operands are turned into magnitudes before the unsigned core. The product is negated when exactly one operand is negative. Elements that the current mode does not use get constant zero operands, so their logic does not toggle.

Top module: `mpmul_array`

## Requirements
- R1: Modes 0, 1 and 2 compute 1, 4 and 9 products of 8-bit operand pairs. Lane i takes `opa[8i+7:8i]` and `opb[8i+7:8i]` and writes its 16-bit product to `prod[16i+15:16i]`.
- R2: Modes 3, 4 and 5 compute 1, 2 and 3 products of 16-bit operand pairs. Lane j takes `opa[16j+15:16j]` and `opb[16j+15:16j]` and writes its 32-bit product to `prod[32j+31:32j]`.
- R3: Mode 6 computes one 32x32 product of `opa[31:0]` and `opb[31:0]` into `prod[63:0]`.
- R4: With `sgn`=0 the operands are unsigned. With `sgn`=1 they are two's complement at the lane width, and the most-negative value is multiplied exactly.
- R5: Every `prod` bit outside the active lanes of the captured mode is zero, whatever the unused operand bits hold.
- R6: Mode 7 produces an all-zero `prod`.
- R7: `out_vld` equals `in_vld` from the previous clock. A transfer with `in_vld`=1 shows its product on `prod` one cycle later.
- R8: When `in_vld` is 0, `prod` keeps its previous value.
- R9: While `rst_n` is low, and after release until the first transfer, `out_vld` and `prod` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| mode | input | 3 | Lane set: 0..2 for 8-bit, 3..5 for 16-bit, 6 for 32-bit, 7 off |
| sgn | input | 1 | 1 selects two's complement operands |
| opa | input | 72 | Packed first operands |
| opb | input | 72 | Packed second operands |
| out_vld | output | 1 | Product register holds a fresh result |
| prod | output | 144 | Packed products |

## Verification
The bench targets the cases where the three-product split breaks. All-ones operands make the half-sums carry out. A design that dropped the carry correction would get the high bits of the 32-bit product wrong, and one with a narrow half-sum path would get the 16-bit lanes wrong. Most-negative operands, signed against signed and signed against unsigned, catch a magnitude conversion or final negation that is off by one or that overflows the lane width. Runs with all-ones in the unused operand bits expose lane steering that leaks into lanes outside the mode. Idle cycles between transfers show whether the product register is held or reloaded.

// File: rtl/mpmul_pkg.sv
package mpmul_pkg;

    localparam int NPE  = 9;
    localparam int NGRP = 3;

    typedef enum logic [2:0] {
        MD_1X8  = 3'd0,
        MD_4X8  = 3'd1,
        MD_9X8  = 3'd2,
        MD_1X16 = 3'd3,
        MD_2X16 = 3'd4,
        MD_3X16 = 3'd5,
        MD_1X32 = 3'd6,
        MD_OFF  = 3'd7
    } mode_e;

    // elements powered for each lane set
    function automatic logic [NPE-1:0] pe_mask(mode_e m);
        case (m)
            MD_1X8:  return 9'h001;
            MD_4X8:  return 9'h00F;
            MD_9X8:  return 9'h1FF;
            MD_1X16: return 9'h007;
            MD_2X16: return 9'h03F;
            MD_3X16: return 9'h1FF;
            MD_1X32: return 9'h1FF;
            default: return 9'h000;
        endcase
    endfunction

    function automatic logic is_wide(mode_e m);
        return (m == MD_1X16) || (m == MD_2X16) || (m == MD_3X16) || (m == MD_1X32);
    endfunction

endpackage

// File: rtl/mpmul_pe.sv
module mpmul_pe #(
    parameter int LW = 8
) (
    input  logic            en,
    input  logic [LW:0]     a,
    input  logic [LW:0]     b,
    output logic [2*LW+1:0] p
);
    localparam int PW = 2*LW+2;

    logic [LW:0] a_g, b_g;

    always_comb begin
        a_g = en ? a : '0;
        b_g = en ? b : '0;
        p   = PW'(a_g) * PW'(b_g);
    end
endmodule

// File: rtl/mpmul_group.sv
module mpmul_group #(
    parameter int LW = 8
) (
    input  logic            wide,
    input  logic [2:0]      en,
    input  logic [3*LW-1:0] la,
    input  logic [3*LW-1:0] lb,
    input  logic [2*LW-1:0] wa,
    input  logic [2*LW-1:0] wb,
    output logic [6*LW-1:0] lp,
    output logic [4*LW-1:0] wp
);
    localparam int PW = 2*LW+2;
    localparam int QW = 4*LW;

    logic [LW:0]   ea [3];
    logic [LW:0]   eb [3];
    logic [PW-1:0] pp [3];
    logic [PW-1:0] mid;

    always_comb begin
        for (int j = 0; j < 3; j++) begin
            ea[j] = {1'b0, la[j*LW +: LW]};
            eb[j] = {1'b0, lb[j*LW +: LW]};
        end
        if (wide) begin
            ea[0] = {1'b0, wa[LW-1:0]};
            eb[0] = {1'b0, wb[LW-1:0]};
            ea[1] = {1'b0, wa[2*LW-1:LW]};
            eb[1] = {1'b0, wb[2*LW-1:LW]};
            ea[2] = {1'b0, wa[LW-1:0]} + {1'b0, wa[2*LW-1:LW]};
            eb[2] = {1'b0, wb[LW-1:0]} + {1'b0, wb[2*LW-1:LW]};
        end
    end

    for (genvar j = 0; j < 3; j++) begin : g_pe
        mpmul_pe #(.LW(LW)) u_pe (
            .en (en[j]),
            .a  (ea[j]),
            .b  (eb[j]),
            .p  (pp[j])
        );
    end

    always_comb begin
        mid = pp[2] - pp[1] - pp[0];
        for (int j = 0; j < 3; j++)
            lp[j*2*LW +: 2*LW] = pp[j][2*LW-1:0];
        wp = (QW'(pp[1]) << (2*LW)) + QW'(pp[0]) + (QW'(mid) << LW);
    end
endmodule

// File: rtl/mpmul_array.sv
module mpmul_array
    import mpmul_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [2:0]         mode,
    input  logic               sgn,
    input  logic [NPE*LW-1:0]  opa,
    input  logic [NPE*LW-1:0]  opb,
    output logic               out_vld,
    output logic [2*NPE*LW-1:0] prod
);
    localparam int HW    = 2*LW;
    localparam int FW    = 4*LW;
    localparam int XW    = FW+2;
    localparam int OUT_W = 2*NPE*LW;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] prod;
    } st_t;

    st_t st_d, st_q;

    mode_e           md;
    logic [NPE-1:0]  pe_on;
    logic [LW-1:0]   m8a [NPE];
    logic [LW-1:0]   m8b [NPE];
    logic            ng8 [NPE];
    logic [HW-1:0]   m16a [NGRP];
    logic [HW-1:0]   m16b [NGRP];
    logic            ng16 [NGRP];
    logic [FW-1:0]   m32a, m32b;
    logic            ng32;
    logic [HW:0]     sa, sb;
    logic            g_wide;
    logic [2:0]      g_en [NGRP];
    logic [3*LW-1:0] g_la [NGRP];
    logic [3*LW-1:0] g_lb [NGRP];
    logic [HW-1:0]   g_wa [NGRP];
    logic [HW-1:0]   g_wb [NGRP];
    logic [6*LW-1:0] g_lp [NGRP];
    logic [FW-1:0]   g_wp [NGRP];
    logic [XW-1:0]   m34, mid34;
    logic [2*FW-1:0] p64;
    logic [HW-1:0]   t16;
    logic [FW-1:0]   t32;
    logic [OUT_W-1:0] res;

    // operand conditioning: sign to magnitude at each lane width
    always_comb begin
        md    = mode_e'(mode);
        pe_on = pe_mask(md);
        for (int i = 0; i < NPE; i++) begin
            m8a[i] = opa[i*LW +: LW];
            m8b[i] = opb[i*LW +: LW];
            if (sgn && m8a[i][LW-1]) m8a[i] = ~m8a[i] + 1'b1;
            if (sgn && m8b[i][LW-1]) m8b[i] = ~m8b[i] + 1'b1;
            ng8[i] = sgn & (opa[i*LW+LW-1] ^ opb[i*LW+LW-1]);
        end
        for (int g = 0; g < NGRP; g++) begin
            m16a[g] = opa[g*HW +: HW];
            m16b[g] = opb[g*HW +: HW];
            if (sgn && m16a[g][HW-1]) m16a[g] = ~m16a[g] + 1'b1;
            if (sgn && m16b[g][HW-1]) m16b[g] = ~m16b[g] + 1'b1;
            ng16[g] = sgn & (opa[g*HW+HW-1] ^ opb[g*HW+HW-1]);
        end
        m32a = opa[FW-1:0];
        m32b = opb[FW-1:0];
        if (sgn && m32a[FW-1]) m32a = ~m32a + 1'b1;
        if (sgn && m32b[FW-1]) m32b = ~m32b + 1'b1;
        ng32 = sgn & (opa[FW-1] ^ opb[FW-1]);
        sa   = {1'b0, m32a[FW-1:HW]} + {1'b0, m32a[HW-1:0]};
        sb   = {1'b0, m32b[FW-1:HW]} + {1'b0, m32b[HW-1:0]};
    end

    // steering into the three groups
    always_comb begin
        g_wide = is_wide(md);
        for (int g = 0; g < NGRP; g++) begin
            g_en[g] = pe_on[3*g +: 3];
            g_la[g] = {m8a[3*g+2], m8a[3*g+1], m8a[3*g]};
            g_lb[g] = {m8b[3*g+2], m8b[3*g+1], m8b[3*g]};
            g_wa[g] = m16a[g];
            g_wb[g] = m16b[g];
        end
        if (md == MD_1X32) begin
            g_wa[0] = m32a[HW-1:0];
            g_wb[0] = m32b[HW-1:0];
            g_wa[1] = m32a[FW-1:HW];
            g_wb[1] = m32b[FW-1:HW];
            g_wa[2] = sa[HW-1:0];
            g_wb[2] = sb[HW-1:0];
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        mpmul_group #(.LW(LW)) u_grp (
            .wide (g_wide),
            .en   (g_en[g]),
            .la   (g_la[g]),
            .lb   (g_lb[g]),
            .wa   (g_wa[g]),
            .wb   (g_wb[g]),
            .lp   (g_lp[g]),
            .wp   (g_wp[g])
        );
    end

    // 32-bit assembly with carry correction of the 17-bit half sums
    always_comb begin
        m34 = XW'(g_wp[2])
            + (sa[HW] ? (XW'(sb[HW-1:0]) << HW) : '0)
            + (sb[HW] ? (XW'(sa[HW-1:0]) << HW) : '0)
            + (XW'(sa[HW] & sb[HW]) << FW);
        mid34 = m34 - XW'(g_wp[1]) - XW'(g_wp[0]);
        p64   = {g_wp[1], g_wp[0]} + ((2*FW)'(mid34) << HW);
    end

    always_comb begin
        res = '0;
        t16 = '0;
        t32 = '0;
        case (md)
            MD_1X8, MD_4X8, MD_9X8: begin
                for (int i = 0; i < NPE; i++) begin
                    if (pe_on[i]) begin
                        t16 = g_lp[i/3][(i%3)*HW +: HW];
                        res[i*HW +: HW] = ng8[i] ? (~t16 + 1'b1) : t16;
                    end
                end
            end
            MD_1X16, MD_2X16, MD_3X16: begin
                for (int g = 0; g < NGRP; g++) begin
                    if (pe_on[3*g]) begin
                        t32 = g_wp[g];
                        res[g*FW +: FW] = ng16[g] ? (~t32 + 1'b1) : t32;
                    end
                end
            end
            MD_1X32: res[2*FW-1:0] = ng32 ? (~p64 + 1'b1) : p64;
            default: res = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_vld;
        if (in_vld) st_d.prod = res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign prod    = st_q.prod;

endmodule

// File: rtl/mpmul_array_chk.sv
module mpmul_array_chk #(
    parameter int LW = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_vld,
    input logic [2:0]          mode,
    input logic                sgn,
    input logic [9*LW-1:0]     opa,
    input logic [9*LW-1:0]     opb,
    input logic                out_vld,
    input logic [18*LW-1:0]    prod
);
    localparam int FW = 4*LW;

    assert_vld_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    assert_idle_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(prod));

    assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 3'd7) |=> (prod == '0));

    assert_upper_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 3'd3) |=> (prod[18*LW-1:FW] == '0));

    assert_wide_unsigned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 3'd6 && !sgn) |=>
        (prod[2*FW-1:0] == ({{FW{1'b0}}, $past(opa[FW-1:0])} * {{FW{1'b0}}, $past(opb[FW-1:0])})));

endmodule

bind mpmul_array mpmul_array_chk #(.LW(LW)) u_chk (.*);

// File: tb/sim_mpmul_array.sv
module sim_mpmul_array;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_vld;
    logic [2:0]   mode;
    logic         sgn;
    logic [71:0]  opa, opb;
    logic         out_vld;
    logic [143:0] prod;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic         exp_v;
    logic [143:0] exp_p;

    always #10 clk = ~clk;

    mpmul_array u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .sgn(sgn),
        .opa(opa), .opb(opb), .out_vld(out_vld), .prod(prod)
    );

    function automatic longint ext(logic [71:0] v, int pos, int w, bit s);
        logic [71:0] sh = v >> pos;
        logic [63:0] x  = sh[63:0];
        longint r;
        x = x & ((64'd1 << w) - 64'd1);
        r = longint'(x);
        if (s && x[w-1]) r = r - (longint'(1) << w);
        return r;
    endfunction

    function automatic logic [143:0] ref_prod(logic [2:0] m, bit s, logic [71:0] a, logic [71:0] b);
        logic [143:0] r = '0;
        int w = 8;
        int n = 0;
        logic [63:0] pu;
        case (m)
            3'd0: begin w = 8;  n = 1; end
            3'd1: begin w = 8;  n = 4; end
            3'd2: begin w = 8;  n = 9; end
            3'd3: begin w = 16; n = 1; end
            3'd4: begin w = 16; n = 2; end
            3'd5: begin w = 16; n = 3; end
            3'd6: begin w = 32; n = 1; end
            default: n = 0;
        endcase
        for (int i = 0; i < n; i++) begin
            pu = 64'(ext(a, i*w, w, s) * ext(b, i*w, w, s));
            if (2*w < 64) pu = pu & ((64'd1 << (2*w)) - 64'd1);
            r = r | (144'(pu) << (i*2*w));
        end
        return r;
    endfunction

    function automatic string tag_of(bit v, logic [2:0] m, bit s);
        string t;
        if (!v) return "R8";
        case (m)
            3'd0, 3'd1, 3'd2: t = "R1";
            3'd3, 3'd4, 3'd5: t = "R2";
            3'd6:             t = "R3";
            default:          t = "R6";
        endcase
        if (m != 3'd2 && m != 3'd5 && m != 3'd7) t = {t, " R5"};
        if (s) t = {t, " R4"};
        return t;
    endfunction

    task automatic chk(string tag, logic [143:0] act, logic [143:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic step(bit v, logic [2:0] m, bit s, logic [71:0] a, logic [71:0] b);
        in_vld = v; mode = m; sgn = s; opa = a; opb = b;
        if (v) exp_p = ref_prod(m, s, a, b);
        exp_v = v;
        @(negedge clk);
        chk("R7", 144'(out_vld), 144'(exp_v));
        chk(tag_of(v, m, s), prod, exp_p);
    endtask

    function automatic logic [71:0] rnd72();
        logic [95:0] t = {$urandom, $urandom, $urandom};
        return t[71:0];
    endfunction

    function automatic logic [71:0] negpat(logic [2:0] m);
        if (m <= 3'd2) return {9{8'h80}};
        if (m <= 3'd5) return {8'h00, {4{16'h8000}}};
        return {40'h0, 32'h8000_0000};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_vld = 1'b1; mode = 3'd6; sgn = 1'b0;
        opa = {72{1'b1}}; opb = {72{1'b1}};
        exp_v = 1'b0; exp_p = '0;
        repeat (3) @(negedge clk);
        chk("R9", 144'(out_vld), 144'd0);
        chk("R9", prod, 144'd0);
        in_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", 144'(out_vld), 144'd0);
        chk("R9", prod, 144'd0);

        // directed corners in every mode
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 2; s++) begin
                step(1'b1, 3'(m), s[0], {72{1'b1}}, {72{1'b1}});
                step(1'b1, 3'(m), s[0], negpat(3'(m)), negpat(3'(m)));
                step(1'b1, 3'(m), s[0], negpat(3'(m)), {72{1'b1}});
                step(1'b0, 3'(m), s[0], rnd72(), rnd72());
                step(1'b1, 3'(m), s[0], '0, {72{1'b1}});
                step(1'b1, 3'(m), s[0], rnd72(), rnd72());
            end
        end
        // half-sum carries: low and high halves both near full scale
        step(1'b1, 3'd6, 1'b0, {40'h0, 32'hFFFF_FFFF}, {40'h0, 32'hFFFF_8001});
        step(1'b1, 3'd5, 1'b0, {24'h0, 48'hFFFF_FF01_80FF}, {24'h0, 48'hFF80_FFFF_FF7F});
        step(1'b1, 3'd6, 1'b1, {40'hFF_FFFF_FFFF, 32'h7FFF_FFFF}, {40'h0, 32'h8000_0000});

        // random traffic with idle gaps
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 4) != 0, 3'($urandom % 8), 1'($urandom % 2), rnd72(), rnd72());
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule